// File: doc/BRIEF.md
# Narrow-Port Chip-Select Bus Sequencer

This block is a bus master that turns an internal read or write request into cycles on an external bus. The bus has a data port eight bits wide. A word request of 16 bits is split into two byte beats. The sequencer drives transfer start, the address, an access-type attribute, an active-low chip select and an active-low byte write enable. The selected device ends each beat by pulling a transfer-acknowledge input low. Until it does, the sequencer adds wait states. Read bytes come from the top byte lane of the data bus and are packed into a 16-bit result.

Two options are latched with each request. The address-setup option holds chip select high for one clock after the address changes. The read-hold option keeps the address and attribute driven for one extra clock after each acknowledged read beat. A bus-monitor limit is read live from an input. When it is non-zero and a beat stalls longer than the limit, the access ends with an error pulse and the sequencer returns to idle.

Top module: `cs_bus_seq`

## Requirements
- R1: `req_ready` is high only in idle, and a request is taken only while it is high. The clock after acceptance is the start clock: `ts_n` low, `atm` low, the address driven, and `cs_n` low only if address setup is off.
- R2: In every data clock, `ts_n` is high, `atm` is high and `cs_n` is low.
- R3: `ta_n` is sampled on each rising edge in a data clock. While it is high and no error occurs, the beat repeats with the address held. An access with no error takes 1 + (data clocks) + (hold clocks) + (setup clocks) busy clocks.
- R4: On a word read, the first acknowledged byte goes to `rdata[15:8]` and the second to `rdata[7:0]`. A byte read puts its byte in `rdata[7:0]` with `rdata[15:8]` zero.
- R5: A word request must carry an even address. Its second beat drives the address with bit 0 set. A byte request drives its address unchanged.
- R6: Write data on `dout` is `wdata[15:8]` on the first beat of a word, and `wdata[7:0]` on the second beat or on a byte access.
- R7: With read hold on, each acknowledged read beat is followed by one clock with the address and `atm` held and `cs_n` high.
- R8: With address setup on, `cs_n` stays high in the start clock and in one clock after the address steps to the second beat, before data clocks begin.
- R9: With address setup on, `we_n` is low only in data clocks after the first one of a beat. A zero-wait write beat therefore writes nothing. With setup off, `we_n` is low in every data clock of a write.
- R10: If `cfg_bmt` is non-zero and `ta_n` is still high at the end of data clock number `cfg_bmt` of a beat, `bus_err` pulses, the sequencer goes idle with `cs_n` high, and no further beat is issued. An acknowledge in that last clock completes normally. A value of zero disables the monitor.
- R11: `done` is a one-cycle pulse after the final beat and any hold clock. It never coincides with `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access in two beats, 0 = single byte |
| req_addr | input | AW | Byte address (even for word accesses) |
| req_wdata | input | 16 | Write data |
| cfg_aset | input | 1 | Address-setup option, latched per request |
| cfg_rhold | input | 1 | Read-hold option, latched per request |
| cfg_bmt | input | TW | Bus-monitor limit in data clocks, 0 = off |
| req_ready | output | 1 | Idle, ready to accept |
| done | output | 1 | Access completed pulse |
| bus_err | output | 1 | Bus-monitor abort pulse |
| rdata | output | 16 | Assembled read data |
| ts_n | output | 1 | Transfer start, active low |
| atm | output | 1 | Access-type attribute, high in data phase |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Byte write enable, active low |
| addr | output | AW | Bus address |
| dout | output | 8 | Write byte |
| din | input | 8 | Read byte from the top data lane |
| ta_n | input | 1 | Transfer acknowledge, active low |

## Verification
The acknowledge of a beat and the expiry of the bus monitor can fall on the same rising edge. This happens when the device answers in data clock number `cfg_bmt`. Directed cases place the acknowledge exactly there and one clock later. Random cases draw the wait counts and limits from overlapping small ranges, so both outcomes also occur with address setup and read hold active. The bench expects the acknowledge to win when it lands in the last allowed clock. It judges this from `done` against `bus_err`, from the data taken, and from the number of acknowledged beats.

// File: rtl/cs_bus_seq.sv
module cs_bus_seq #(
  parameter int AW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic          cfg_aset,
  input  logic          cfg_rhold,
  input  logic [TW-1:0] cfg_bmt,
  output logic          req_ready,
  output logic          done,
  output logic          bus_err,
  output logic [15:0]   rdata,
  output logic          ts_n,
  output logic          atm,
  output logic          cs_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [7:0]    dout,
  input  logic [7:0]    din,
  input  logic          ta_n
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_HOLD, S_SETUP} st_t;

  st_t           st;
  logic [AW-1:0] a_q;
  logic [15:0]   wd_q;
  logic          wr_q, word_q, aset_q, rhold_q, beat;
  logic [TW-1:0] bm_cnt;

  wire last    = !word_q || beat;
  wire timeout = (cfg_bmt != '0) && (bm_cnt == cfg_bmt - 1'b1);

  assign req_ready = (st == S_IDLE);
  assign ts_n      = !(st == S_START);
  assign atm       = (st == S_DATA) || (st == S_HOLD) || (st == S_SETUP);
  assign cs_n      = !((st == S_DATA) || (st == S_START && !aset_q));
  assign we_n      = !((st == S_DATA) && wr_q && (!aset_q || bm_cnt != '0));
  assign addr      = (st == S_IDLE) ? '0 : {a_q[AW-1:1], a_q[0] | beat};
  assign dout      = (st == S_IDLE || !wr_q) ? 8'h00 :
                     (word_q && !beat) ? wd_q[15:8] : wd_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      aset_q  <= 1'b0;
      rhold_q <= 1'b0;
      beat    <= 1'b0;
      bm_cnt  <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      bus_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_START;
          a_q     <= req_addr;
          wd_q    <= req_wdata;
          wr_q    <= req_write;
          word_q  <= req_word;
          aset_q  <= cfg_aset;
          rhold_q <= cfg_rhold;
          beat    <= 1'b0;
          rdata   <= '0;
        end
        S_START: begin
          st     <= S_DATA;
          bm_cnt <= '0;
        end
        S_DATA: if (!ta_n) begin
          bm_cnt <= '0;
          if (!wr_q) begin
            if (word_q && !beat) rdata[15:8] <= din;
            else                 rdata[7:0]  <= din;
          end
          if (!wr_q && rhold_q) st <= S_HOLD;
          else if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            beat <= 1'b1;
            st   <= aset_q ? S_SETUP : S_DATA;
          end
        end else if (timeout) begin
          st      <= S_IDLE;
          bus_err <= 1'b1;
          bm_cnt  <= '0;
        end else begin
          bm_cnt <= bm_cnt + 1'b1;
        end
        S_HOLD: if (last) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else begin
          beat   <= 1'b1;
          bm_cnt <= '0;
          st     <= aset_q ? S_SETUP : S_DATA;
        end
        S_SETUP: begin
          st     <= S_DATA;
          bm_cnt <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cs_bus_seq_chk.sv
module cs_bus_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          bus_err,
  input logic          ts_n,
  input logic          atm,
  input logic          cs_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic          ta_n
);

  AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !ts_n |=> ts_n); // R1
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_n && ts_n && we_n && !atm)); // R1
  AST_DATA_ATTR: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && atm) |-> ts_n); // R2
  AST_WAIT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && atm && ta_n) |=> (bus_err || $stable(addr))); // R3
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (!cs_n && atm)); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> (cs_n && req_ready)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n) !(done && bus_err)); // R11

endmodule

bind cs_bus_seq cs_bus_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .bus_err(bus_err),
  .ts_n(ts_n), .atm(atm), .cs_n(cs_n), .we_n(we_n), .addr(addr), .ta_n(ta_n)
);

// File: tb/cs_bus_seq_bench.sv
module cs_bus_seq_bench;
  localparam int AW = 8;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic cfg_aset = 0, cfg_rhold = 0;
  logic [TW-1:0] cfg_bmt = '0;
  logic req_ready, done, bus_err, ts_n, atm, cs_n, we_n;
  logic [15:0] rdata;
  logic [AW-1:0] addr;
  logic [7:0] dout;
  logic [7:0] din = 8'h00;
  logic ta_n = 1;

  cs_bus_seq #(.AW(AW), .TW(TW)) u_cs_bus_seq (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [7:0] mem [256];
  int want0 = 0, want1 = 0, bi = 0, wcnt = 0;
  int cs_low = 0, we_low = 0, acks = 0;
  logic [AW-1:0] cur_a = '0;
  logic cur_word = 0;

  task automatic check(string rq, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // device model: acknowledges beat bi after want wait clocks
  always @(negedge clk) begin
    if (!cs_n) cs_low++;
    if (!we_n) we_low++;
    if (!cs_n && atm) begin
      if (wcnt == ((bi == 0) ? want0 : want1)) begin
        check("R5", int'(addr), cur_word ? int'({cur_a[7:1], bi[0]}) : int'(cur_a), "beat address");
        if (!we_n) mem[addr] = dout;
        din  = mem[addr];
        ta_n = 0;
        acks++;
        bi++;
        wcnt = 0;
      end else begin
        ta_n = 1;
        wcnt++;
      end
    end else begin
      ta_n = 1;
      wcnt = 0;
    end
  end

  function automatic int err_beat(bit word, int bmt, int w0, int w1);
    if (bmt != 0 && w0 >= bmt) return 0;
    if (word && bmt != 0 && w1 >= bmt) return 1;
    return -1;
  endfunction

  function automatic int data_clks(int w, bit aset, bit wr);
    return (wr && aset) ? w : w + 1;
  endfunction

  task automatic run(bit wr, bit word, logic [7:0] a, logic [15:0] wd, bit aset, bit rhold,
                     int bmt, int w0, int w1);
    int nb = word ? 2 : 1;
    int eb = err_beat(word, bmt, w0, w1);
    int ok_beats = (eb < 0) ? nb : eb;
    logic [7:0] a0 = word ? {a[7:1], 1'b0} : a;
    logic [7:0] a1 = {a[7:1], 1'b1};
    logic [7:0] pre0 = mem[a0], pre1 = mem[a1];
    logic [7:0] e0 = pre0, e1 = pre1;
    int exp_lat = 1, exp_cs = aset ? 0 : 1, exp_we = 0, lat = 0, guard = 0;
    int ws [2];
    ws[0] = w0; ws[1] = w1;
    for (int i = 0; i < nb; i++) begin
      int dc = (i == eb) ? bmt : ws[i] + 1;
      exp_cs += dc;
      exp_lat += dc;
      if (wr) exp_we += aset ? dc - 1 : dc;
      if (i == eb) break;
      if (!wr && rhold) exp_lat++;
      if (wr && !(aset && ws[i] == 0)) begin
        if (word && i == 0) e0 = wd[15:8];
        else if (word) e1 = wd[7:0];
        else e0 = wd[7:0];
      end
    end
    if (word && aset && (eb < 0 || eb == 1)) exp_lat++;
    want0 = w0; want1 = w1; bi = 0; wcnt = 0;
    cs_low = 0; we_low = 0; acks = 0;
    cur_a = a0; cur_word = word;
    check("R1", int'(req_ready), 1, "ready before request");
    req_valid = 1; req_write = wr; req_word = word; req_addr = a0;
    req_wdata = wd; cfg_aset = aset; cfg_rhold = rhold; cfg_bmt = TW'(bmt);
    @(negedge clk);
    req_valid = 0;
    check("R1", int'(!ts_n && !atm && (cs_n == aset)), 1, "start clock signals");
    while (!done && !bus_err && guard < 400) begin
      lat++;
      guard++;
      @(negedge clk);
    end
    check("R10", int'(bus_err), int'(eb >= 0), "error outcome");
    check("R11", int'(done), int'(eb < 0), "done outcome");
    check("R2", cs_low, exp_cs, "chip select low clocks");
    check("R9", we_low, exp_we, "write enable low clocks");
    check("R10", acks, ok_beats, "acknowledged beats");
    if (eb < 0) begin
      check("R3", lat, exp_lat, "busy clocks (R7 R8)");
      if (!wr) begin
        if (word) check("R4", int'(rdata), int'({pre0, pre1}), "word read data");
        else      check("R4", int'(rdata), int'({8'h00, pre0}), "byte read data");
      end
    end else begin
      check("R10", int'(cs_n), 1, "cs after error");
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R10", int'(cs_n && ts_n), 1, "quiet after error");
      end
    end
    if (wr) begin
      check("R6", int'(mem[a0]), int'(e0), "first byte written");
      if (word) check("R6", int'(mem[a1]), int'(e1), "second byte written");
    end
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7351);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(req_ready && ts_n && cs_n && we_n && !done && !bus_err), 1, "reset outputs");
    check("R4", int'(rdata), 0, "reset rdata");
    run(0, 1, 8'h20, 16'h0, 1, 1, 0, 0, 0);    // R7 R8 word read, zero wait
    run(1, 1, 8'h40, 16'hA55A, 1, 0, 0, 0, 2); // R9 zero-wait first beat writes nothing
    run(1, 1, 8'h42, 16'h1234, 0, 0, 0, 0, 0); // R6 R9 no setup
    run(0, 0, 8'h33, 16'h0, 0, 1, 0, 1, 0);    // R4 R5 odd byte read
    run(0, 1, 8'h50, 16'h0, 0, 0, 3, 3, 0);    // R10 timeout first beat
    run(0, 1, 8'h52, 16'h0, 1, 0, 3, 2, 2);    // R10 ack in last allowed clock
    run(1, 1, 8'h54, 16'hBEEF, 1, 1, 0, 20, 9); // R10 monitor off
    run(1, 1, 8'h56, 16'hC0DE, 1, 0, 2, 1, 2); // R10 timeout second beat
    for (int n = 0; n < 200; n++) begin
      bit wr = 1'($urandom);
      bit word = 1'($urandom);
      logic [7:0] a = 8'($urandom);
      int bmt = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 4);
      run(wr, word, word ? {a[7:1], 1'b0} : a, 16'($urandom), 1'($urandom), 1'($urandom),
          bmt, int'($urandom % 5), int'($urandom % 5));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule